// File: doc/BRIEF.md
# Decimal Digit Ripple Adder

This block adds two packed 8421 BCD numbers of `NDIG` digits plus a carry-in and returns a BCD sum of the same width and a decimal carry-out. It has no clock and no state. Each digit slice works without a binary add followed by a +6 fix-up. Its least significant bit pair goes through a plain full adder. Its three upper bits are added in units of two, and a +3 correction is merged into that addition.

The low full-adder carry is then folded into the upper 3-bit field through an XOR/mux chain. One leftover case is patched at the end: the field equals 4 and the low carry is set. In that case the field is cleared and a carry is sent to the next digit. The carry-out of a slice is a mux that takes either the upper adder's carry or the low carry, which keeps the low carry's path to the next digit short. The slices are chained into a ripple adder by a generate loop.

Operands with digits above 9 are not handled, and neither is subtraction.

Top module: `bcd_ripple_adder`

## Requirements
- R1: For a single digit with both operands in 0..9 and either carry-in value, 10 × carry-out + sum digit equals a + b + carry-in.
- R2: Every sum digit is in the range 0..9 whenever all operand digits are in 0..9.
- R3: The carry-out of a digit is 1 exactly when a + b + carry-in of that digit is 10 or more.
- R4: For `NDIG` digits, the packed sum read as a decimal number, plus carry-out × 10^NDIG, equals A + B + carry-in. Digit k of each operand and of the sum sits in bits 4k+3..4k.
- R5: When every digit of A is 9, B is zero and carry-in is 1, all sum digits are 0 and carry-out is 1.
- R6: Consider a digit whose bits 3:1 of both operands sum to 4 and whose bit-0 full adder produces a carry. Its sum digit equals the full adder's sum bit (0 or 1), and its carry-out is 1.
- R7: Zero operands with carry-in 0 give a zero sum and carry-out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*NDIG | Packed BCD operand A, digit 0 in the low nibble |
| b_i | input | 4*NDIG | Packed BCD operand B, digit 0 in the low nibble |
| cin_i | input | 1 | Decimal carry into digit 0 |
| sum_o | output | 4*NDIG | Packed BCD sum |
| cout_o | output | 1 | Decimal carry out of the top digit |

## Verification
The bench builds two copies of the block. A copy with `NDIG` = 1 is swept through all 200 digit and carry-in combinations, which covers every path through the merged +3 and the final patch. A copy with `NDIG` = 4 takes random four-digit sums plus directed ones. Among the directed sums is the all-nines carry chain, which makes a carry ripple through every slice and reach the output.

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
  parameter int NDIG = 4,
  localparam int W = 4 * NDIG
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [NDIG:0] cy;
  assign cy[0]  = cin_i;
  assign cout_o = cy[NDIG];

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic [3:0] x, y, hs, hr, dig;
    logic [2:0] f, z;
    logic       s0, c0, k1, k2, fix;

    assign x = a_i[4*d +: 4];
    assign y = b_i[4*d +: 4];

    // bit 0 of both operands plus the incoming carry
    assign s0 = x[0] ^ y[0] ^ cy[d];
    assign c0 = (x[0] & y[0]) | (cy[d] & (x[0] ^ y[0]));

    // upper bits in units of two, decimal correction merged
    assign hs = {1'b0, x[3:1]} + {1'b0, y[3:1]};
    assign hr = (hs >= 4'd5) ? hs + 4'd3 : hs;
    assign f  = hr[2:0];

    // fold c0 into the field: xor for sum, mux passes carry on a one
    assign z[0] = f[0] ^ c0;
    assign k1   = f[0] ? c0 : 1'b0;
    assign z[1] = f[1] ^ k1;
    assign k2   = f[1] ? k1 : 1'b0;
    assign z[2] = f[2] ^ k2;

    assign fix = c0 & (f == 3'd4);
    assign dig = {fix ? 3'b000 : z, s0};
    assign sum_o[4*d +: 4] = dig;
    assign cy[d+1] = (f == 3'd4) ? c0 : hr[3];

    always_comb begin
      if (x <= 4'd9 && y <= 4'd9) begin
        assert_field_range_R2: assert (f <= 3'd4 && hr <= 4'd11)
          else $error("merged field out of range");
        assert_digit_valid_R2: assert (sum_o[4*d +: 4] <= 4'd9)
          else $error("sum digit above nine");
        assert_digit_value_R1: assert (10 * int'(cy[d+1]) + int'(sum_o[4*d +: 4])
                                       == int'(x) + int'(y) + int'(cy[d]))
          else $error("digit sum mismatch");
        if (fix) begin
          assert_patch_R6: assert (sum_o[4*d +: 4] == {3'b000, s0} && cy[d+1])
            else $error("final patch not applied");
        end
      end
    end
  end

endmodule

// File: tb/bcd_ripple_adder_bench.sv
module bcd_ripple_adder_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4*N-1:0] a, b, s;
  logic           ci, co;
  logic [3:0]     a1, b1, s1;
  logic           ci1, co1;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bcd_ripple_adder #(.NDIG(N)) u_bcd_ripple_adder (
    .a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co));
  bcd_ripple_adder #(.NDIG(1)) u_bcd_ripple_adder_one (
    .a_i(a1), .b_i(b1), .cin_i(ci1), .sum_o(s1), .cout_o(co1));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4*N-1:0] to_bcd(input longint v);
    logic [4*N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic longint from_bcd(input logic [4*N-1:0] v);
    longint r = 0;
    for (int i = N - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic bit digits_ok(input logic [4*N-1:0] v);
    for (int i = 0; i < N; i++) if (v[4*i +: 4] > 4'd9) return 0;
    return 1;
  endfunction

  longint pow10;

  task automatic run_multi(input longint av, input longint bv, input bit c, input string req);
    longint tot;
    @(negedge clk);
    a = to_bcd(av); b = to_bcd(bv); ci = c;
    @(posedge clk); #1;
    tot = av + bv + longint'(c);
    check(req, from_bcd(s) + longint'(co) * pow10, tot);
    check("R2", longint'(digits_ok(s)), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    pow10 = 1;
    for (int i = 0; i < N; i++) pow10 = pow10 * 10;
    a = '0; b = '0; ci = 1'b0; a1 = '0; b1 = '0; ci1 = 1'b0;
    @(posedge clk); #1;
    // R7: zero in, zero out
    check("R7 sum", longint'(s), 0);
    check("R7 cout", longint'(co), 0);

    // exhaustive single digit: R1, R2, R3, R6
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 10; x++)
        for (int y = 0; y < 10; y++) begin
          @(negedge clk);
          a1 = 4'(x); b1 = 4'(y); ci1 = 1'(c);
          @(posedge clk); #1;
          check("R1", 10 * longint'(co1) + longint'(s1), longint'(x + y + c));
          check("R2", longint'(s1 <= 4'd9), 1);
          check("R3", longint'(co1), longint'((x + y + c) >= 10));
          if (((x >> 1) + (y >> 1)) == 4 && ((x & 1) + (y & 1) + c) >= 2) begin
            check("R6 digit", longint'(s1), longint'((x + y + c) & 1));
            check("R6 cout", longint'(co1), 1);
          end
        end

    // R5: carry ripples through every nine
    run_multi(pow10 - 1, 0, 1'b1, "R5");
    check("R5 zero sum", longint'(s), 0);
    check("R5 cout", longint'(co), 1);
    run_multi(pow10 - 1, pow10 - 1, 1'b1, "R4 max");
    run_multi(5555, 4445, 1'b0, "R4 chain");

    // R4: random multi-digit sums
    for (int i = 0; i < 300; i++)
      run_multi(longint'($urandom % 32'(pow10)), longint'($urandom % 32'(pow10)),
                1'($urandom % 2), "R4");

    finish_run();
  end
endmodule